// File: doc/BRIEF.md
# LCD Panel Register Access Engine

This block performs register accesses to a display panel controller over an 18-bit parallel bus of the 8080 kind. The bus has an active-low chip select, a register-select line (low = command/index, high = data), an active-low write strobe, an active-low read-enable strobe and an 18-bit data bus. The data bus is split into an output word, an output enable and an input word, so the pad logic elsewhere can build the tristate buffer.

A host issues one request at a time. Each request is either a register write (index then value) or a register read (index, then a read phase on the enable strobe). Sixteen-bit quantities are spread over the 18-bit bus with an unused gap bit at positions 0 and 9, and read data is packed back the same way. Four 8-bit timing counts, captured when a request is accepted, set how many clock cycles the setup and hold windows around each strobe last.

Top module: `lcd_regbus_engine`

## Requirements
- R1: After a synchronous active-low reset and whenever the engine is idle, chip select, register-select, write strobe and read-enable are all 1, the bus output enable is 0, `busy` and `done` are 0, and after reset `rdData` is 0.
- R2: A 16-bit quantity q is driven on the bus as {q[15:8], 1'b0, q[7:0], 1'b0}: the low byte on bits 8:1, the high byte on bits 17:10, and bits 0 and 9 at 0.
- R3: A write request produces a command transfer, then a data transfer, with chip select held low for both. In the command transfer, register-select is 0 and the mapped index is driven. The bus is held for the command setup window, then the write strobe is low for the command hold window, then high for one cycle. The data transfer repeats this with register-select 1, the mapped value, and the data setup and data hold windows.
- R4: A read request first holds every line high for one cycle with the bus driven to zero. Register-select, chip select and the write strobe then fall in that order, one cycle apart.
- R5: In a read, the mapped index is driven with the write strobe low for the command setup window. The strobe is then high for the command hold window. The bus is released (output enable 0) one cycle before read-enable first falls, and it stays released to the end of the read.
- R6: In the read phase, read-enable goes low for one cycle. Register-select then rises with read-enable still low, and read-enable is high for the data setup window. Read-enable is then low for the data hold window, and the bus input is sampled on its last cycle. Read-enable then rises for one cycle, and chip select rises for one cycle. `rdData` becomes {bus[17:10], bus[8:1]}, with bus bits 0 and 9 ignored.
- R7: The number of cycles in each window is the count latched when the request was accepted. A count of 0 acts as 1.
- R8: `reqAck` is high in exactly the cycles where `reqValid` is high and the engine is idle. A request presented while `busy` is high is ignored and leaves the running sequence unchanged.
- R9: `done` is a one-cycle pulse in the first idle cycle after a sequence ends. A new request can be accepted in that same cycle. `rdData` changes only when a read samples the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqIsRead | input | 1 | 1 = register read, 0 = register write |
| reqIndex | input | 16 | Register index |
| reqValue | input | 16 | Value for a write |
| cmdSetup | input | CNT_W | Command setup window, cycles |
| cmdHold | input | CNT_W | Command hold window, cycles |
| dataSetup | input | CNT_W | Data setup window, cycles |
| dataHold | input | CNT_W | Data hold window, cycles |
| reqAck | output | 1 | Request accepted this cycle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished pulse |
| rdData | output | 16 | Last read result |
| lcdCsN | output | 1 | Chip select, active low |
| lcdRs | output | 1 | Register select, 0 command, 1 data |
| lcdWrN | output | 1 | Write strobe, active low |
| lcdEnN | output | 1 | Read enable strobe, active low |
| busOut | output | 18 | Bus word driven |
| busOe | output | 1 | Bus output enable |
| busIn | input | 18 | Bus word sampled |

## Verification
The bench builds the engine with the default 8-bit counters. It runs the same write and read sequences under three timing sets: the default counts 2/2/1/2, all counts 0, and wider counts 5/3/7/4. This exercises both the clamp from zero to one cycle and windows long enough that an off-by-one in any wait shows as a shifted edge. The bus input carries 1s in the gap bits and distinct byte patterns, so a wrong unpacking or a wrong sampling cycle changes `rdData`. Requests are also offered while the engine is busy and held across the done cycle, which checks that busy requests are dropped and that back-to-back requests start in the done cycle.

// File: rtl/lcd_regbus_pkg.sv
package lcd_regbus_pkg;

  localparam int BusW  = 18;
  localparam int ValW  = 16;
  localparam int StepW = 4;

  typedef enum logic {
    OP_WRITE = 1'b0,
    OP_READ  = 1'b1
  } opKind_e;

  typedef enum logic [2:0] {
    WAIT_ONE,
    WAIT_CMD_SETUP,
    WAIT_CMD_HOLD,
    WAIT_DATA_SETUP,
    WAIT_DATA_HOLD
  } waitSel_e;

  typedef enum logic [1:0] {
    SRC_ZERO,
    SRC_INDEX,
    SRC_VALUE
  } busSrc_e;

  // One entry of the bus sequence: line levels, bus source and window length
  typedef struct packed {
    logic     csN;
    logic     rs;
    logic     wrN;
    logic     enN;
    logic     drive;
    busSrc_e  src;
    logic     sample;
    waitSel_e waitSel;
    logic     last;
  } stepCfg_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic    load;
    logic    drive;
    busSrc_e src;
    logic    capture;
  } busCtl_t;

  function automatic logic [BusW-1:0] packWord(input logic [ValW-1:0] q);
    return {q[15:8], 1'b0, q[7:0], 1'b0};
  endfunction

  function automatic logic [ValW-1:0] unpackWord(input logic [BusW-1:0] w);
    return {w[17:10], w[8:1]};
  endfunction

  function automatic stepCfg_t mk(input logic csN, input logic rs, input logic wrN,
                                  input logic enN, input logic drive, input busSrc_e src,
                                  input logic sample, input waitSel_e ws, input logic last);
    stepCfg_t s;
    s.csN = csN; s.rs = rs; s.wrN = wrN; s.enN = enN;
    s.drive = drive; s.src = src; s.sample = sample;
    s.waitSel = ws; s.last = last;
    return s;
  endfunction

  function automatic stepCfg_t idleStep();
    return mk(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, SRC_ZERO, 1'b0, WAIT_ONE, 1'b0);
  endfunction

  function automatic stepCfg_t writeStep(input logic [StepW-1:0] idx);
    case (idx)
      4'd0:    return mk(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, SRC_INDEX, 1'b0, WAIT_CMD_SETUP,  1'b0);
      4'd1:    return mk(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, SRC_INDEX, 1'b0, WAIT_CMD_HOLD,   1'b0);
      4'd2:    return mk(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, SRC_INDEX, 1'b0, WAIT_ONE,        1'b0);
      4'd3:    return mk(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, SRC_VALUE, 1'b0, WAIT_DATA_SETUP, 1'b0);
      4'd4:    return mk(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, SRC_VALUE, 1'b0, WAIT_DATA_HOLD,  1'b0);
      4'd5:    return mk(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, SRC_VALUE, 1'b0, WAIT_ONE,        1'b1);
      default: return idleStep();
    endcase
  endfunction

  function automatic stepCfg_t readStep(input logic [StepW-1:0] idx);
    case (idx)
      4'd0:    return mk(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, SRC_ZERO,  1'b0, WAIT_ONE,        1'b0);
      4'd1:    return mk(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, SRC_ZERO,  1'b0, WAIT_ONE,        1'b0);
      4'd2:    return mk(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, SRC_ZERO,  1'b0, WAIT_ONE,        1'b0);
      4'd3:    return mk(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, SRC_ZERO,  1'b0, WAIT_ONE,        1'b0);
      4'd4:    return mk(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, SRC_INDEX, 1'b0, WAIT_CMD_SETUP,  1'b0);
      4'd5:    return mk(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, SRC_INDEX, 1'b0, WAIT_CMD_HOLD,   1'b0);
      4'd6:    return mk(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, SRC_ZERO,  1'b0, WAIT_ONE,        1'b0);
      4'd7:    return mk(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, SRC_ZERO,  1'b0, WAIT_ONE,        1'b0);
      4'd8:    return mk(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, SRC_ZERO,  1'b0, WAIT_ONE,        1'b0);
      4'd9:    return mk(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, SRC_ZERO,  1'b0, WAIT_DATA_SETUP, 1'b0);
      4'd10:   return mk(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, SRC_ZERO,  1'b1, WAIT_DATA_HOLD,  1'b0);
      4'd11:   return mk(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, SRC_ZERO,  1'b0, WAIT_ONE,        1'b0);
      4'd12:   return mk(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, SRC_ZERO,  1'b0, WAIT_ONE,        1'b1);
      default: return idleStep();
    endcase
  endfunction

  function automatic stepCfg_t stepOf(input opKind_e op, input logic [StepW-1:0] idx);
    return (op == OP_READ) ? readStep(idx) : writeStep(idx);
  endfunction

endpackage

// File: rtl/lcd_regbus_ctrl.sv
module lcd_regbus_ctrl
  import lcd_regbus_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqIsRead,
  input  logic [CNT_W-1:0] cmdSetup,
  input  logic [CNT_W-1:0] cmdHold,
  input  logic [CNT_W-1:0] dataSetup,
  input  logic [CNT_W-1:0] dataHold,
  output logic             reqAck,
  output logic             busy,
  output logic             done,
  output logic             lcdCsN,
  output logic             lcdRs,
  output logic             lcdWrN,
  output logic             lcdEnN,
  output busCtl_t          busCtl
);

  localparam logic [CNT_W-1:0] CntOne  = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [StepW-1:0] StepOne = {{(StepW-1){1'b0}}, 1'b1};

  logic             active;
  opKind_e          opQ;
  logic [StepW-1:0] stepIdx;
  logic [CNT_W-1:0] waitCnt;
  logic [CNT_W-1:0] cmdSetupQ, cmdHoldQ, dataSetupQ, dataHoldQ;
  logic             doneQ;

  stepCfg_t curCfg, nxtCfg, firstCfg;
  opKind_e  reqOp;
  logic     accept;
  logic     windowEnd;

  // Window length in cycles for a selector, with zero clamped to one
  function automatic logic [CNT_W-1:0] windowLen(input waitSel_e ws,
      input logic [CNT_W-1:0] cs, input logic [CNT_W-1:0] ch,
      input logic [CNT_W-1:0] ds, input logic [CNT_W-1:0] dh);
    logic [CNT_W-1:0] n;
    case (ws)
      WAIT_CMD_SETUP:  n = cs;
      WAIT_CMD_HOLD:   n = ch;
      WAIT_DATA_SETUP: n = ds;
      WAIT_DATA_HOLD:  n = dh;
      default:         n = CntOne;
    endcase
    return (n == '0) ? CntOne : n;
  endfunction

  always_comb begin
    reqOp     = reqIsRead ? OP_READ : OP_WRITE;
    accept    = reqValid && !active;
    curCfg    = active ? stepOf(opQ, stepIdx) : idleStep();
    nxtCfg    = stepOf(opQ, stepIdx + StepOne);
    firstCfg  = stepOf(reqOp, '0);
    windowEnd = active && (waitCnt == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active     <= 1'b0;
      opQ        <= OP_WRITE;
      stepIdx    <= '0;
      waitCnt    <= '0;
      cmdSetupQ  <= '0;
      cmdHoldQ   <= '0;
      dataSetupQ <= '0;
      dataHoldQ  <= '0;
      doneQ      <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (accept) begin
        active     <= 1'b1;
        opQ        <= reqOp;
        stepIdx    <= '0;
        cmdSetupQ  <= cmdSetup;
        cmdHoldQ   <= cmdHold;
        dataSetupQ <= dataSetup;
        dataHoldQ  <= dataHold;
        waitCnt    <= windowLen(firstCfg.waitSel, cmdSetup, cmdHold, dataSetup, dataHold) - CntOne;
      end else if (windowEnd) begin
        if (curCfg.last) begin
          active  <= 1'b0;
          stepIdx <= '0;
          doneQ   <= 1'b1;
        end else begin
          stepIdx <= stepIdx + StepOne;
          waitCnt <= windowLen(nxtCfg.waitSel, cmdSetupQ, cmdHoldQ, dataSetupQ, dataHoldQ) - CntOne;
        end
      end else if (active) begin
        waitCnt <= waitCnt - CntOne;
      end
    end
  end

  always_comb begin
    reqAck         = accept;
    busy           = active;
    done           = doneQ;
    lcdCsN         = curCfg.csN;
    lcdRs          = curCfg.rs;
    lcdWrN         = curCfg.wrN;
    lcdEnN         = curCfg.enN;
    busCtl.load    = accept;
    busCtl.drive   = curCfg.drive;
    busCtl.src     = curCfg.src;
    busCtl.capture = windowEnd && curCfg.sample;
  end

endmodule

// File: rtl/lcd_regbus_datapath.sv
module lcd_regbus_datapath
  import lcd_regbus_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  busCtl_t         busCtl,
  input  logic [ValW-1:0] reqIndex,
  input  logic [ValW-1:0] reqValue,
  input  logic [BusW-1:0] busIn,
  output logic [BusW-1:0] busOut,
  output logic            busOe,
  output logic [ValW-1:0] rdData
);

  logic [ValW-1:0] indexQ;
  logic [ValW-1:0] valueQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      indexQ <= '0;
      valueQ <= '0;
      rdData <= '0;
    end else begin
      if (busCtl.load) begin
        indexQ <= reqIndex;
        valueQ <= reqValue;
      end
      if (busCtl.capture) begin
        rdData <= unpackWord(busIn);
      end
    end
  end

  always_comb begin
    busOe = busCtl.drive;
    if (!busCtl.drive) begin
      busOut = '0;
    end else begin
      case (busCtl.src)
        SRC_INDEX: busOut = packWord(indexQ);
        SRC_VALUE: busOut = packWord(valueQ);
        default:   busOut = '0;
      endcase
    end
  end

endmodule

// File: rtl/lcd_regbus_engine.sv
module lcd_regbus_engine
  import lcd_regbus_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqIsRead,
  input  logic [15:0]      reqIndex,
  input  logic [15:0]      reqValue,
  input  logic [CNT_W-1:0] cmdSetup,
  input  logic [CNT_W-1:0] cmdHold,
  input  logic [CNT_W-1:0] dataSetup,
  input  logic [CNT_W-1:0] dataHold,
  output logic             reqAck,
  output logic             busy,
  output logic             done,
  output logic [15:0]      rdData,
  output logic             lcdCsN,
  output logic             lcdRs,
  output logic             lcdWrN,
  output logic             lcdEnN,
  output logic [17:0]      busOut,
  output logic             busOe,
  input  logic [17:0]      busIn
);

  busCtl_t busCtl;

  lcd_regbus_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqIsRead (reqIsRead),
    .cmdSetup  (cmdSetup),
    .cmdHold   (cmdHold),
    .dataSetup (dataSetup),
    .dataHold  (dataHold),
    .reqAck    (reqAck),
    .busy      (busy),
    .done      (done),
    .lcdCsN    (lcdCsN),
    .lcdRs     (lcdRs),
    .lcdWrN    (lcdWrN),
    .lcdEnN    (lcdEnN),
    .busCtl    (busCtl)
  );

  lcd_regbus_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .busCtl   (busCtl),
    .reqIndex (reqIndex),
    .reqValue (reqValue),
    .busIn    (busIn),
    .busOut   (busOut),
    .busOe    (busOe),
    .rdData   (rdData)
  );

endmodule

// File: rtl/lcd_regbus_checker.sv
module lcd_regbus_checker (
  input logic        clk,
  input logic        rstN,
  input logic        reqAck,
  input logic        busy,
  input logic        done,
  input logic [15:0] rdData,
  input logic        lcdCsN,
  input logic        lcdRs,
  input logic        lcdWrN,
  input logic        lcdEnN,
  input logic [17:0] busOut,
  input logic        busOe
);

  AST_IDLE_LINES_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (lcdCsN && lcdRs && lcdWrN && lcdEnN && !busOe)); // R1

  AST_GAP_BITS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    busOe |-> (busOut[0] == 1'b0 && busOut[9] == 1'b0)); // R2

  AST_WR_STROBE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rstN)
    !lcdWrN |-> (!lcdCsN && busOe)); // R3

  AST_EN_STROBE_BUS_FREE: assert property (@(posedge clk) disable iff (!rstN)
    !lcdEnN |-> (!busOe && lcdWrN)); // R5

  AST_ACK_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |-> !busy); // R8

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done); // R9

  AST_RDDATA_HELD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !$past(busy)) |-> $stable(rdData)); // R9

endmodule

bind lcd_regbus_engine lcd_regbus_checker u_checker (
  .clk    (clk),
  .rstN   (rstN),
  .reqAck (reqAck),
  .busy   (busy),
  .done   (done),
  .rdData (rdData),
  .lcdCsN (lcdCsN),
  .lcdRs  (lcdRs),
  .lcdWrN (lcdWrN),
  .lcdEnN (lcdEnN),
  .busOut (busOut),
  .busOe  (busOe)
);

// File: tb/lcd_regbus_engine_bench.sv
module lcd_regbus_engine_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqIsRead = 1'b0;
  logic [15:0] reqIndex = '0;
  logic [15:0] reqValue = '0;
  logic [7:0]  cmdSetup = 8'd2, cmdHold = 8'd2, dataSetup = 8'd1, dataHold = 8'd2;
  logic [17:0] busIn = '0;
  logic        reqAck, busy, done, lcdCsN, lcdRs, lcdWrN, lcdEnN, busOe;
  logic [15:0] rdData;
  logic [17:0] busOut;

  always #5 clk = ~clk;

  lcd_regbus_engine u_lcd_regbus_engine (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIsRead(reqIsRead),
    .reqIndex(reqIndex), .reqValue(reqValue), .cmdSetup(cmdSetup),
    .cmdHold(cmdHold), .dataSetup(dataSetup), .dataHold(dataHold),
    .reqAck(reqAck), .busy(busy), .done(done), .rdData(rdData),
    .lcdCsN(lcdCsN), .lcdRs(lcdRs), .lcdWrN(lcdWrN), .lcdEnN(lcdEnN),
    .busOut(busOut), .busOe(busOe), .busIn(busIn)
  );

  typedef struct {
    logic [3:0]  lines;   // {csN, rs, wrN, enN}
    logic        oe;
    logic [17:0] bus;
    logic        bsy;
    logic        dn;
    logic [15:0] rd;
    string       tag;
  } expRec_t;

  expRec_t expQ[$];
  int      vectors = 0;
  int      miscompares = 0;
  logic [15:0] lastRd = '0;
  bit      wasIdle = 1'b1;

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not finish, actual hung expected completion");
    summary();
  end

  function automatic logic [17:0] spread(input logic [15:0] q);
    return {q[15:8], 1'b0, q[7:0], 1'b0};
  endfunction

  function automatic int win(input logic [7:0] n);
    return (n == 0) ? 1 : int'(n);
  endfunction

  task automatic push(input int n, input bit csN, input bit rs, input bit wrN, input bit enN,
                      input bit oe, input logic [17:0] bus, input logic [15:0] rd, input string tag);
    expRec_t r;
    r.lines = {csN, rs, wrN, enN}; r.oe = oe; r.bus = bus;
    r.bsy = 1'b1; r.dn = 1'b0; r.rd = rd; r.tag = tag;
    for (int k = 0; k < n; k++) expQ.push_back(r);
  endtask

  task automatic pushDone(input logic [15:0] rd);
    expRec_t r;
    r.lines = 4'b1111; r.oe = 1'b0; r.bus = '0;
    r.bsy = 1'b0; r.dn = 1'b1; r.rd = rd; r.tag = "R9";
    expQ.push_back(r);
  endtask

  // Expected cycle stream of a write (R3 R7, bus mapping R2)
  task automatic buildWrite(input logic [15:0] idx, input logic [15:0] val);
    push(win(cmdSetup),  0, 0, 1, 1, 1, spread(idx), lastRd, "R3 R7");
    push(win(cmdHold),   0, 0, 0, 1, 1, spread(idx), lastRd, "R3 R7");
    push(1,              0, 0, 1, 1, 1, spread(idx), lastRd, "R3");
    push(win(dataSetup), 0, 1, 1, 1, 1, spread(val), lastRd, "R3 R7");
    push(win(dataHold),  0, 1, 0, 1, 1, spread(val), lastRd, "R3 R7");
    push(1,              0, 1, 1, 1, 1, spread(val), lastRd, "R3");
    pushDone(lastRd);
  endtask

  // Expected cycle stream of a read (R4 R5 R6 R7)
  task automatic buildRead(input logic [15:0] idx, input logic [17:0] word);
    logic [15:0] nr;
    nr = {word[17:10], word[8:1]};
    push(1,              1, 1, 1, 1, 1, 18'd0,       lastRd, "R4");
    push(1,              1, 0, 1, 1, 1, 18'd0,       lastRd, "R4");
    push(1,              0, 0, 1, 1, 1, 18'd0,       lastRd, "R4");
    push(1,              0, 0, 0, 1, 1, 18'd0,       lastRd, "R4");
    push(win(cmdSetup),  0, 0, 0, 1, 1, spread(idx), lastRd, "R5 R7");
    push(win(cmdHold),   0, 0, 1, 1, 1, spread(idx), lastRd, "R5 R7");
    push(1,              0, 0, 1, 1, 0, 18'd0,       lastRd, "R5");
    push(1,              0, 0, 1, 0, 0, 18'd0,       lastRd, "R6");
    push(1,              0, 1, 1, 0, 0, 18'd0,       lastRd, "R6");
    push(win(dataSetup), 0, 1, 1, 1, 0, 18'd0,       lastRd, "R6 R7");
    push(win(dataHold),  0, 1, 1, 0, 0, 18'd0,       lastRd, "R6 R7");
    push(1,              0, 1, 1, 1, 0, 18'd0,       nr,     "R6");
    push(1,              1, 1, 1, 1, 0, 18'd0,       nr,     "R6");
    pushDone(nr);
  endtask

  task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // One clock: compare outputs of this cycle with the model, then advance it
  task automatic tick();
    expRec_t c;
    @(negedge clk);
    if (expQ.size() > 0) c = expQ.pop_front();
    else begin
      c.lines = 4'b1111; c.oe = 1'b0; c.bus = '0; c.bsy = 1'b0; c.dn = 1'b0;
      c.rd = lastRd; c.tag = "R1";
    end
    cmp(c.tag, "lines{csN,rs,wrN,enN}", {28'd0, lcdCsN, lcdRs, lcdWrN, lcdEnN}, {28'd0, c.lines});
    cmp(c.tag, "busOe", {31'd0, busOe}, {31'd0, c.oe});
    if (c.oe) cmp("R2", "busOut", {14'd0, busOut}, {14'd0, c.bus});
    cmp("R8", "busy", {31'd0, busy}, {31'd0, c.bsy});
    cmp("R9", "done", {31'd0, done}, {31'd0, c.dn});
    cmp("R6 R9", "rdData", {16'd0, rdData}, {16'd0, c.rd});
    lastRd  = c.rd;
    wasIdle = !c.bsy;
  endtask

  // Present a request until accepted, optionally poke while busy, run to idle
  task automatic doOp(input bit rd, input logic [15:0] idx, input logic [15:0] val,
                      input logic [17:0] word, input int pokes);
    bit acc;
    busIn = word; reqValid = 1'b1; reqIsRead = rd; reqIndex = idx; reqValue = val;
    acc = 1'b0;
    while (!acc) begin
      #1;
      acc = wasIdle;
      cmp("R8", "reqAck", {31'd0, reqAck}, {31'd0, acc});
      if (acc) begin
        if (rd) buildRead(idx, word); else buildWrite(idx, val);
      end
      tick();
    end
    reqValid = 1'b0;
    for (int p = 0; p < pokes && expQ.size() > 2; p++) begin
      // R8: a request while busy is dropped; the running stream must not change
      reqValid = 1'b1; reqIsRead = ~rd; reqIndex = ~idx; reqValue = ~val;
      #1;
      cmp("R8", "reqAck while busy", {31'd0, reqAck}, 32'd0);
      tick();
    end
    reqValid = 1'b0; reqIndex = idx; reqValue = val;
    while (expQ.size() > 0) tick();
    tick();
  endtask

  initial begin
    // R1: reset state
    rstN = 1'b0;
    repeat (3) tick();
    cmp("R1", "rdData after reset", {16'd0, rdData}, 32'd0);
    rstN = 1'b1;
    repeat (2) tick();

    // Default timing 2/2/1/2
    doOp(1'b0, 16'h00e5, 16'h78f0, 18'h00000, 0);
    doOp(1'b1, 16'h0000, 16'h0000, 18'h2a6b5, 0);   // gap bits 0 and 9 set
    doOp(1'b0, 16'h8001, 16'hffff, 18'h00000, 0);

    // All windows zero: clamp to one cycle (R7)
    cmdSetup = 0; cmdHold = 0; dataSetup = 0; dataHold = 0;
    doOp(1'b1, 16'h1234, 16'h0000, 18'h3fdfe, 0);
    doOp(1'b0, 16'ha5c3, 16'h5a3c, 18'h00000, 0);

    // Wider windows, with busy pokes (R8)
    cmdSetup = 5; cmdHold = 3; dataSetup = 7; dataHold = 4;
    doOp(1'b0, 16'h0129, 16'h0014, 18'h00000, 4);
    doOp(1'b1, 16'hfe01, 16'h0000, 18'h00201, 6);   // only gap bits set
    doOp(1'b1, 16'h0f0f, 16'h0000, 18'h1fd02, 2);

    // Back-to-back: next request held high across the done cycle (R9)
    cmdSetup = 1; cmdHold = 2; dataSetup = 1; dataHold = 1;
    reqValid = 1'b1; reqIsRead = 1'b0; reqIndex = 16'h0022; reqValue = 16'h0173;
    #1;
    cmp("R8", "reqAck", {31'd0, reqAck}, {31'd0, wasIdle});
    if (wasIdle) buildWrite(16'h0022, 16'h0173);
    tick();
    while (expQ.size() > 1) tick();
    // next cycle is the done cycle: request still high must be taken there
    reqIsRead = 1'b1; reqIndex = 16'h00aa; busIn = 18'h15555;
    tick();
    #1;
    cmp("R9", "reqAck in done cycle", {31'd0, reqAck}, {31'd0, wasIdle});
    if (wasIdle) buildRead(16'h00aa, 18'h15555);
    tick();
    reqValid = 1'b0;
    while (expQ.size() > 0) tick();
    repeat (3) tick();

    summary();
  end

endmodule